// File: doc/BRIEF.md
# I2C Byte Shift Engine with Bus Readback

This block moves one byte at a time across a two-wire serial bus whose clock line (SCL) is supplied from outside. Software loads a byte into a single shift register. The register then presents its bits on the data line through an open-drain pull-down, most significant bit first. On every rising SCL edge the block samples the real level of the data line back into the same register. After eight bits it holds the byte that was actually on the bus. A transmitter can therefore compare that byte with what it meant to send.

The block also holds a programmable address byte and compares it continuously against the shift register. After a transmit, the match output reports whether the byte on the wire equals the programmed value, which serves as a transmit error check. For reception, software loads all ones so that the pull-down never engages. A wake mode keeps the line released whatever the register holds. A write made while a slave is stretching the clock is held pending until the stretch ends. When a byte completes, a sticky done flag is raised.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset the shift register and address register read 0, the done flag and busy read 0, the pull-down is off, and match reads 1.
- R2: Transmit bits leave most significant bit first. The first bit is presented one cycle after the starting write, and each later bit is presented after a falling edge of the synchronized SCL.
- R3: On each rising edge of the synchronized SCL during a transfer, the register shifts left and takes the sampled data-line level into bit 0. The sampled level is the wired-AND of the block's own output and any other driver.
- R4: A write starts a transfer only when the enable input is already 1 and no transfer is under way. A write with the enable at 0 loads the register but starts nothing, and raising the enable afterwards does not start a transfer either.
- R5: A write made while a transfer is under way has no effect on the register or on the byte that results.
- R6: After the eighth rising edge the transfer stops on its own (busy returns to 0) and the done flag is set. The flag stays set until a clear pulse; if a set and a clear coincide, the set wins.
- R7: If the wait input is 1 when a transfer starts, the transfer stays pending: SCL edges neither shift nor count. Shifting begins once the wait input returns to 0.
- R8: The pull-down output is 1 only while a transfer is pending or running, the current output bit is 0, and wake mode is off.
- R9: The match output is 1 exactly when the shift register equals the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_en | input | 1 | Interface enable; must be 1 before a starting write |
| wake_mode | input | 1 | Keeps the data line released when 1 |
| hold_req | input | 1 | Slave wait state active (clock stretched) |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| shift_wr | input | 1 | Write strobe for the shift register |
| shift_wdata | input | W | Byte written to the shift register |
| shift_rdata | output | W | Current shift register contents |
| addr_wr | input | 1 | Write strobe for the address register |
| addr_wdata | input | W | Byte written to the address register |
| addr_match | output | 1 | Shift register equals address register |
| done_flag | output | 1 | Sticky end-of-byte flag |
| done_clr | input | 1 | Clears the done flag |
| busy | output | 1 | Transfer pending or running |

## Verification
The assertions assume that SCL and SDA come from an asynchronous bus and change slowly compared with the system clock. Each level must hold for several cycles so that the two-stage synchronizer resolves every edge. They also assume that the wait input changes only while SCL is low. The stimulus keeps every SCL phase at eight system cycles and moves the wait input only during a low phase. The data line is modelled as a wired-AND of the block's pull-down and a bench-side pull-down, and the bench changes its own pull-down only while SCL is low.

// File: rtl/i2c_shift_pkg.sv
// Package: shared types for the byte shift engine.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_shift_pkg;
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_PEND = 2'd1,
        SH_RUN  = 2'd2
    } sh_state_t;
endpackage

// File: rtl/bit_sync.sv
// Module: bit_sync
// Carries one asynchronous level into the clk domain through a chain of flops.
// Assumes: STAGES >= 2; the input holds each level for several clk cycles.
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/addr_compare.sv
// Module: addr_compare
// Holds the programmable address byte and compares it with the shift register.
// Assumes: the compare is read as a level, so no registering of the result.
module addr_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         addr_wr,
    input  logic [W-1:0] addr_wdata,
    input  logic [W-1:0] shift_q,
    output logic         match
);
    logic [W-1:0] addr_q;

    // Load the address register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_wr) addr_q <= addr_wdata;
    end

    // Report equality of the shifted byte and the address.
    always_comb match = (shift_q == addr_q);

    // R9: a change of address alone (shift register steady) moves match to the new compare
    a_r9_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr && (addr_wdata == shift_q) && $stable(shift_q) |=> match || !$stable(shift_q));
endmodule

// File: rtl/byte_shift_core.sv
// Module: byte_shift_core
// Sequences one byte: start qualification, wait holding, MSB-first output on
// SCL falls, capture on SCL rises, bit counting and the sticky done flag.
// Assumes: scl_s and sda_s are already synchronized to clk.
module byte_shift_core
    import i2c_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         if_en,
    input  logic         wake_mode,
    input  logic         hold_req,
    input  logic         scl_s,
    input  logic         sda_s,
    input  logic         shift_wr,
    input  logic [W-1:0] shift_wdata,
    output logic [W-1:0] shift_q,
    output logic         pull_low,
    output logic         done_flag,
    input  logic         done_clr,
    output logic         busy
);
    localparam int          CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sh_state_t     state;
    logic [CW-1:0] bit_cnt;
    logic          out_bit;
    logic          scl_prev;
    logic          scl_rise;
    logic          scl_fall;
    logic          start;
    logic          byte_done;

    // Remember the previous synchronized SCL for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_prev <= 1'b1;
        else        scl_prev <= scl_s;
    end

    // Decode edges, start qualification and end of byte.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start     = shift_wr & if_en & (state == SH_IDLE);
        byte_done = (state == SH_RUN) & scl_rise & (bit_cnt == LAST);
    end

    // Main sequencer: load, hold, shift and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            shift_q <= '0;
            bit_cnt <= '0;
            out_bit <= 1'b1;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (shift_wr) shift_q <= shift_wdata;
                    if (start) begin
                        bit_cnt <= '0;
                        out_bit <= shift_wdata[W-1];
                        state   <= hold_req ? SH_PEND : SH_RUN;
                    end
                end
                SH_PEND: begin
                    if (!hold_req) state <= SH_RUN;
                end
                SH_RUN: begin
                    if (scl_rise) begin
                        shift_q <= {shift_q[W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) state <= SH_IDLE;
                    end else if (scl_fall) begin
                        out_bit <= shift_q[W-1];
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Sticky end-of-byte flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_flag <= 1'b0;
        else if (byte_done) done_flag <= 1'b1;
        else if (done_clr)  done_flag <= 1'b0;
    end

    // Open-drain control and busy indication.
    always_comb begin
        busy     = (state != SH_IDLE);
        pull_low = busy & ~out_bit & ~wake_mode;
    end

    // R8: the line is never pulled while idle
    a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pull_low);
    // R8: wake mode always releases the line
    a_r8_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
        wake_mode |-> !pull_low);
    // R6: done flag holds until cleared
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !done_clr |=> done_flag);
    // R6: completing a byte returns to idle
    a_r6_stop_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !busy && done_flag);
    // R5: a write during a transfer does not touch the register except by a shift
    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && shift_wr && !scl_rise |=> $stable(shift_q));
    // R7: nothing shifts while pending
    a_r7_pending_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state == SH_PEND |=> $stable(shift_q) && $stable(bit_cnt));
    // R4: idle with the enable low stays idle
    a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !if_en |=> !busy);
endmodule

// File: rtl/i2c_byte_shifter.sv
// Module: i2c_byte_shifter (top)
// Byte shift engine for a two-wire bus: synchronizes SCL/SDA, runs the shift
// core and compares the register with a programmable address.
// Assumes: SCL comes from outside; start/stop and acknowledge are handled elsewhere.
module i2c_byte_shifter #(
    parameter int W       = 8,
    parameter int SYNC_FF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         if_en,
    input  logic         wake_mode,
    input  logic         hold_req,
    input  logic         scl_in,
    input  logic         sda_in,
    output logic         sda_pull_low,
    input  logic         shift_wr,
    input  logic [W-1:0] shift_wdata,
    output logic [W-1:0] shift_rdata,
    input  logic         addr_wr,
    input  logic [W-1:0] addr_wdata,
    output logic         addr_match,
    output logic         done_flag,
    input  logic         done_clr,
    output logic         busy
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;

    assign raw_lines = {sda_in, scl_in};

    // One synchronizer per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        bit_sync #(.STAGES(SYNC_FF), .RST_VAL(1'b1)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_async(raw_lines[g]),
            .q_sync (sync_lines[g])
        );
    end

    byte_shift_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_en      (if_en),
        .wake_mode  (wake_mode),
        .hold_req   (hold_req),
        .scl_s      (sync_lines[0]),
        .sda_s      (sync_lines[1]),
        .shift_wr   (shift_wr),
        .shift_wdata(shift_wdata),
        .shift_q    (shift_rdata),
        .pull_low   (sda_pull_low),
        .done_flag  (done_flag),
        .done_clr   (done_clr),
        .busy       (busy)
    );

    addr_compare #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (addr_wr),
        .addr_wdata(addr_wdata),
        .shift_q   (shift_rdata),
        .match     (addr_match)
    );
endmodule

// File: tb/i2c_byte_shifter_test.sv
// Scoreboard bench: the driver pushes expected bytes, the monitor pops them
// when the done flag rises and compares.
module i2c_byte_shifter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_en = 1'b0, wake_mode = 1'b0, hold_req = 1'b0;
    logic       scl = 1'b0, ext_low = 1'b0;
    logic       sda_line;
    logic       pull;
    logic       shift_wr = 1'b0, addr_wr = 1'b0, done_clr = 1'b0;
    logic [7:0] shift_wdata = '0, addr_wdata = '0, rdata;
    logic       match, done_flag, busy;
    logic       done_q = 1'b0;
    int         total = 0, bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = ~(pull | ext_low);

    i2c_byte_shifter uut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .wake_mode(wake_mode),
        .hold_req(hold_req), .scl_in(scl), .sda_in(sda_line),
        .sda_pull_low(pull), .shift_wr(shift_wr), .shift_wdata(shift_wdata),
        .shift_rdata(rdata), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .addr_match(match), .done_flag(done_flag), .done_clr(done_clr),
        .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_pulse();
        ticks(8); scl = 1'b1; ticks(8); scl = 1'b0;
    endtask

    // Monitor: on each rise of the done flag compare data and match.
    always @(negedge clk) begin
        if (rst_n && done_flag && !done_q) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected done", 1, 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " R3 readback"}, rdata, e[7:0]);
                chk({t, " R9 match"}, match, e[8]);
            end
        end
        done_q <= done_flag;
    end

    // Driver: one full byte with optional bench pull-downs, hold and busy write.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] pull_mask,
                        input logic [7:0] addr_val, input bit use_hold,
                        input bit mid_wr, input string tag);
        logic [7:0] expv;
        addr_wr = 1'b1; addr_wdata = addr_val; ticks(1); addr_wr = 1'b0;
        expv = (wake_mode ? 8'hFF : tx) & ~pull_mask;
        exp_q.push_back({expv == addr_val, expv});
        tag_q.push_back(tag);
        hold_req = use_hold;
        shift_wr = 1'b1; shift_wdata = tx; ticks(1); shift_wr = 1'b0;
        if (use_hold) begin
            for (int k = 0; k < 3; k++) scl_pulse();
            ticks(8);
            chk("R7 register frozen while pending", rdata, tx);
            chk("R7 no done while pending", done_flag, 0);
            chk("R7 busy while pending", busy, 1);
            hold_req = 1'b0;
            ticks(4);
        end
        for (int i = 7; i >= 0; i--) begin
            ext_low = pull_mask[i];
            ticks(8);
            chk("R2/R8 output bit", pull, !wake_mode && !tx[i]);
            if (mid_wr && i == 4) begin
                shift_wr = 1'b1; shift_wdata = 8'h00; ticks(1); shift_wr = 1'b0;
            end
            scl = 1'b1; ticks(8); scl = 1'b0;
        end
        ext_low = 1'b0;
        ticks(8);
        chk("R6 done set", done_flag, 1);
        ticks(20);
        chk("R6 done sticky", done_flag, 1);
        chk("R6 stopped", busy, 0);
        chk("R8 released after byte", pull, 0);
        done_clr = 1'b1; ticks(1); done_clr = 1'b0;
        ticks(1);
        chk("R6 done cleared", done_flag, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        ticks(4);
        rst_n = 1'b1;
        ticks(2);
        chk("R1 register reset", rdata, 8'h00);
        chk("R1 done reset", done_flag, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 line released", pull, 0);
        chk("R1 match reset", match, 1);

        // R4: write with enable low loads but does not start
        shift_wr = 1'b1; shift_wdata = 8'h55; ticks(1); shift_wr = 1'b0;
        ticks(2);
        chk("R4 loaded without enable", rdata, 8'h55);
        chk("R4 no start without enable", busy, 0);
        if_en = 1'b1;
        ticks(4);
        chk("R4 late enable no start", busy, 0);
        scl_pulse(); scl_pulse();
        ticks(8);
        chk("R4 no shift after late enable", rdata, 8'h55);
        chk("R4 no done after late enable", done_flag, 0);

        // R2 R3 R9: clean transmit, address equals byte
        xfer(8'hA5, 8'h00, 8'hA5, 1'b0, 1'b0, "tx clean");
        // R3 R9: collision on two bits, address holds intended byte
        xfer(8'h3C, 8'h24, 8'h3C, 1'b0, 1'b0, "tx collision");
        // R3: receive by loading all ones
        xfer(8'hFF, 8'h69, 8'h00, 1'b0, 1'b0, "rx");
        // R8: wake mode releases the line even for zeros
        wake_mode = 1'b1;
        xfer(8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, "wake");
        wake_mode = 1'b0;
        // R5: write during transfer ignored
        xfer(8'hC3, 8'h00, 8'h11, 1'b0, 1'b1, "busy write");
        // R7: pending while held
        xfer(8'h81, 8'h00, 8'h81, 1'b1, 1'b0, "hold");

        ticks(4);
        chk("R6 all bytes seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule